// File: doc/BRIEF.md
# Streaming ASCII Decimal Integer Parser

This block turns a stream of ASCII characters into a signed 32-bit two's complement integer. A start pulse arms it, and it then pulls one character per cycle through a valid/ready handshake. It skips any leading blanks, takes at most one sign character, and builds the number from the decimal digits that follow. The first character that is not a digit ends the scan.

When the scan ends, the block raises a one-cycle done pulse. At the same time it presents the value, an error flag, zero/sign/parity/carry style status flags, and the position of the character that stopped the scan. Magnitudes too large for the result, and numbers with no digits at all, produce an error with a zero result. The most negative value is accepted only when it is written with a minus sign. The block sits next to whatever supplies the character stream, such as a command-line interpreter, a configuration loader or a protocol front end.

Top module: `ascii_int_parser`

## Requirements
- R1: While no sign and no digit has been taken, a space character (0x20) is consumed and discarded, and it advances the character index by one.
- R2: One '+' (0x2B) or '-' (0x2D) may follow the blanks. A '-' makes the result negative. The character right after the sign must be a digit: any other character, including a second sign or a space, ends the scan with no digit seen.
- R3: Each digit byte 0x30..0x39 sets the magnitude to ten times the old magnitude plus the digit's low four bits. Leading zeros therefore never cause an error.
- R4: Any byte that is not a digit ends the scan once digits are underway, or once a sign has been taken, or once something other than a blank or sign appears before that. The terminating byte is consumed. term_idx reports its zero-based position counted from the first byte after start.
- R5: A scan that ends before any digit is an error.
- R6: A magnitude above 2147483647 is an error. The single exception is a magnitude of exactly 2147483648 with a '-', which yields 0x80000000. Overflow is detected on the digit that causes it, and the scan still runs to the terminator.
- R7: On error: value is 0, err is 1, zf is 1, pf is 1, sf is 0 and cf is 0.
- R8: On success: err and cf are 0, zf is 1 exactly when value is 0, sf equals value bit 31, and pf is 1 exactly when value bits 7..0 contain an even number of ones.
- R9: done is high for exactly one cycle, in the cycle after the terminator is accepted. The outputs hold until the next done. in_ready is low while idle, and high in every cycle from the start pulse until the terminator is taken.
- R10: A start pulse at any time, even in the middle of a scan, throws away the scan in progress and begins a new one at index 0 with no sign and no digits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new scan |
| in_valid | input | 1 | Character byte is present |
| in_data | input | 8 | ASCII character |
| in_ready | output | 1 | Block takes the byte this cycle |
| done | output | 1 | One-cycle result strobe |
| value | output | 32 | Parsed two's complement value |
| err | output | 1 | No digits or magnitude out of range |
| zf | output | 1 | Result is zero |
| sf | output | 1 | Result sign bit |
| pf | output | 1 | Even parity of result low byte |
| cf | output | 1 | Carry-style flag, always cleared |
| term_idx | output | 16 | Position of the terminating byte |

## Verification
If the internal scan state is wrong, the effect shows at the ports on the very next accepted byte. A byte meant to be skipped or accumulated instead ends the scan, so done arrives early and term_idx is off. A lost sign or a stale overflow mark shows up only in the cycle of the done pulse, as a wrong value, a wrong err or wrong flags. Restarts in the middle of a scan and the sequences right around the range limit expose any state that survives a start pulse or a saturated accumulator.

// File: rtl/ascii_int_parser.sv
module ascii_int_parser #(
  parameter int VW = 32,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          done,
  output logic [VW-1:0] value,
  output logic          err,
  output logic          zf,
  output logic          sf,
  output logic          pf,
  output logic          cf,
  output logic [IW-1:0] term_idx
);
  localparam int AW = VW + 4;
  localparam logic [AW-1:0] LIMIT = AW'(1) << (VW - 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SIGNED, S_DIGITS} state_t;

  state_t        state;
  logic [AW-1:0] acc;
  logic [IW-1:0] idx;
  logic          neg, seen, ovf;

  wire is_digit = (in_data >= 8'h30) && (in_data <= 8'h39);
  wire is_space = in_data == 8'h20;
  wire is_sign  = (in_data == 8'h2B) || (in_data == 8'h2D);
  wire take     = in_valid && in_ready;

  wire [AW-1:0] acc_next = (acc << 3) + (acc << 1) + AW'(in_data[3:0]);
  wire          big      = acc_next > LIMIT;

  wire lead_end = (state == S_LEAD) && !is_space && !is_sign && !is_digit;
  wire term     = take && (lead_end || (state != S_LEAD && !is_digit));

  wire          fin_err = !seen || ovf || (!neg && acc == LIMIT);
  wire [VW-1:0] mag     = acc[VW-1:0];
  wire [VW-1:0] result  = fin_err ? '0 : (neg ? (~mag + 1'b1) : mag);

  assign in_ready = state != S_IDLE;
  assign cf = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      acc   <= '0;
      idx   <= '0;
      neg   <= 1'b0;
      seen  <= 1'b0;
      ovf   <= 1'b0;
    end else if (start) begin
      state <= S_LEAD;
      acc   <= '0;
      idx   <= '0;
      neg   <= 1'b0;
      seen  <= 1'b0;
      ovf   <= 1'b0;
    end else if (take) begin
      idx <= idx + 1'b1;
      if (term) begin
        state <= S_IDLE;
      end else if (is_digit) begin
        state <= S_DIGITS;
        seen  <= 1'b1;
        if (!ovf) begin
          if (big) ovf <= 1'b1;
          else     acc <= acc_next;
        end
      end else if (state == S_LEAD && is_sign) begin
        state <= S_SIGNED;
        neg   <= in_data == 8'h2D;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      value    <= '0;
      err      <= 1'b0;
      zf       <= 1'b0;
      sf       <= 1'b0;
      pf       <= 1'b0;
      term_idx <= '0;
    end else begin
      done <= term && !start;
      if (term && !start) begin
        value    <= result;
        err      <= fin_err;
        zf       <= result == '0;
        sf       <= result[VW-1];
        pf       <= ~^result[7:0];
        term_idx <= idx;
      end
    end
  end
endmodule

// File: rtl/ascii_int_parser_chk.sv
module ascii_int_parser_chk #(
  parameter int VW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          in_ready,
  input logic          done,
  input logic [VW-1:0] value,
  input logic          err,
  input logic          zf,
  input logic          sf,
  input logic          pf,
  input logic          cf
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |-> !in_ready); // R9
  AST_START_READY: assert property (@(posedge clk) disable iff (!rst_n) start |=> in_ready); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> (value == '0 && zf && pf && !sf)); // R7
  AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !cf); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!done && !$past(done) && !$past(start)) |-> $stable(value) || !$past(rst_n)); // R9
endmodule

bind ascii_int_parser ascii_int_parser_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .in_ready(in_ready), .done(done),
  .value(value), .err(err), .zf(zf), .sf(sf), .pf(pf), .cf(cf)
);

// File: tb/sim_ascii_int_parser.sv
module sim_ascii_int_parser;
  logic clk = 0, rst_n = 0, start = 0, in_valid = 0;
  logic [7:0] in_data = 0;
  logic in_ready, done, err, zf, sf, pf, cf;
  logic [31:0] value;
  logic [15:0] term_idx;
  int checks = 0, fails = 0;
  logic [7:0] buf_s [0:63];
  int len;
  logic [31:0] exp_val;
  logic exp_err;
  int exp_idx;

  always #5 clk = ~clk;

  ascii_int_parser u0 (.clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .done(done), .value(value), .err(err),
    .zf(zf), .sf(sf), .pf(pf), .cf(cf), .term_idx(term_idx));

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog R9 actual=hung expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_parse();
    int st = 0;
    longint mag = 0;
    bit neg = 0, seen = 0, ovf = 0;
    exp_idx = -1;
    for (int i = 0; i < len; i++) begin
      logic [7:0] c = buf_s[i];
      bit dg = c >= 8'h30 && c <= 8'h39;
      if (dg) begin
        seen = 1; st = 2;
        if (!ovf) begin
          mag = mag * 10 + c[3:0];
          if (mag > 64'd2147483648) ovf = 1;
        end
      end else if (st == 0 && c == 8'h20) begin
      end else if (st == 0 && (c == 8'h2B || c == 8'h2D)) begin
        st = 1; neg = c == 8'h2D;
      end else begin
        exp_idx = i;
        break;
      end
    end
    exp_err = !seen || ovf || (!neg && mag == 64'd2147483648);
    exp_val = exp_err ? 32'd0 : (neg ? 32'(-mag) : 32'(mag));
  endfunction

  task automatic run_parse(input string tag);
    ref_parse();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i <= exp_idx; i++) begin
      in_valid = 1; in_data = buf_s[i];
      chk({tag, " R9 ready"}, in_ready, 1);
      @(negedge clk);
      if (i < exp_idx && done) chk({tag, " R4 early done"}, 1, 0);
    end
    in_valid = 0;
    chk({tag, " R9 done"}, done, 1);
    chk({tag, " R6 value"}, value, exp_val);
    chk({tag, " R5 err"}, err, exp_err);
    chk({tag, " R4 idx"}, term_idx, exp_idx);
    chk({tag, " R8 zf"}, zf, exp_val == 0);
    chk({tag, " R8 sf"}, sf, exp_val[31]);
    chk({tag, " R8 pf"}, pf, ~^exp_val[7:0]);
    chk({tag, " R7 cf"}, cf, 0);
    @(negedge clk);
    chk({tag, " R9 pulse"}, done, 0);
    chk({tag, " R9 idle"}, in_ready, 0);
  endtask

  task automatic load(input string s);
    len = s.len();
    for (int i = 0; i < len; i++) buf_s[i] = s[i];
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk("R9 reset done", done, 0);
    chk("R9 reset ready", in_ready, 0);
    rst_n = 1;
    load("2147483647 ");    run_parse("R6 max");
    load("-2147483648,");   run_parse("R6 min");
    load("2147483648 ");    run_parse("R6 pos over");
    load("-2147483649 ");   run_parse("R6 neg over");
    load("99999999999999x"); run_parse("R6 long");
    load("000000000000000000042 "); run_parse("R3 zeros");
    load("   -0x");         run_parse("R1 negzero");
    load("+-5 ");           run_parse("R2 twosign");
    load("- 5 ");           run_parse("R2 blanksign");
    load("  ,");            run_parse("R5 nodigit");
    load("a");              run_parse("R5 letter");
    load("  +123a");        run_parse("R3 plus");
    buf_s[0] = 8'h37; buf_s[1] = 8'h00; len = 2; run_parse("R4 nul");
    // R10: restart in mid-scan
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    in_valid = 1; in_data = 8'h2D; @(negedge clk);
    in_data = 8'h39; @(negedge clk);
    in_valid = 0;
    load("7 ");             run_parse("R10 restart");
    for (int n = 0; n < 300; n++) begin
      int p = 0;
      int sp = $urandom_range(0, 3);
      int sg = $urandom_range(0, 2);
      int nd = $urandom_range(0, 12);
      int tc = $urandom_range(0, 5);
      logic [7:0] terms [0:5] = '{8'h20, 8'h2C, 8'h61, 8'h00, 8'h2B, 8'h2E};
      for (int k = 0; k < sp; k++) buf_s[p++] = 8'h20;
      if (sg == 1) buf_s[p++] = 8'h2B;
      if (sg == 2) buf_s[p++] = 8'h2D;
      for (int k = 0; k < nd; k++) buf_s[p++] = 8'h30 + 8'($urandom_range(0, 9));
      buf_s[p++] = terms[tc];
      len = p;
      run_parse("R3 rand");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule